// File: doc/BRIEF.md
# Segmented DAC Linearity Test Code Sequencer

This block walks the digital input of a segmented 16-bit converter under test through the smallest set of codes from which its whole transfer curve can be rebuilt. Each code is held on the code bus for a programmable number of clock cycles. In the final cycle of that hold a one-cycle capture strobe tells an external meter to take its reading. A 6-bit measurement index names the table entry being driven, and a done flag marks the end of the sweep.

The set has 59 entries and follows this order:
- zero scale;
- the four binary-weighted low bits, each switched on alone above mid-scale;
- the second and third segments, also stepped above mid-scale;
- the 31 equal-weight top-segment levels, which are measured against zero scale;
- full scale.

An interleave mode inserts the bitwise complement of each top-segment code directly after that code. This keeps the average power in the load resistors, and so their heating, roughly constant across the sweep. A start pulse begins or restarts the sweep at any time.

Top module: `linearity_seq`

## Requirements
- R1: After reset, `code` is 0x0000, `index` is 0, and `strobe`, `comp` and `done` are all 0.
- R2: In table mode (`interleave`=0) the sweep has 59 steps, and step `i` drives `index`=i with the following code:
  - i=0: 0x0000;
  - i=1..4: 0x8000 with bit i-1 also set;
  - i=5..11: 0x8000+0x10*(i-4);
  - i=12..26: 0x8000+0x80*(i-11);
  - i=27..57: 0x800*(i-26);
  - i=58: 0xFFFF.
- R3: Each step holds its code for D cycles, where D is the `dwell` value sampled with start and a `dwell` of 0 counts as 1. The first step begins in the cycle after the clock edge that samples `start`.
- R4: `strobe` is high for exactly one cycle per step, in the last cycle of that step's hold.
- R5: In interleave mode (`interleave`=1) each top-segment step (index 27..57) is followed by one extra step with the same index, `comp`=1 and the bitwise complement of that code. For example, 0x4800 is followed by 0xB7FF. No other entry gets such a step, and `comp` is 0 on every other step. The sweep then has 90 steps.
- R6: `interleave` and `dwell` are sampled only on the start edge. Changing them during a sweep has no effect on the codes or their timing.
- R7: `done` rises in the cycle after the strobe of the full-scale step and stays high until the next start. While `done` is high, `code` stays at 0xFFFF and no strobe occurs.
- R8: A start pulse during a sweep abandons it. The sweep begins again at index 0, with `comp`=0 and `done`=0, timed from that start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start or restart pulse |
| interleave | input | 1 | 1: insert complement steps after top-segment codes |
| dwell | input | 16 | Hold length in clock cycles, sampled at start |
| code | output | 16 | Code driven to the converter under test |
| strobe | output | 1 | One-cycle capture request at the end of each hold |
| index | output | 6 | Table entry of the current step |
| comp | output | 1 | Current step is the complement of a top-segment code |
| done | output | 1 | Sweep finished; held until the next start |

## Verification
The sweep is run in table order with a multi-cycle dwell and in interleave mode with a short dwell. These two runs separate correct segment arithmetic and ordering from any error in placing the complement steps. A zero dwell exposes off-by-one faults in the hold counter. A run in which `interleave` and `dwell` change partway through shows whether either input leaks past the start edge. A restart issued after ten readings shows that index, phase and timer all return to their first-step state. On every cycle of every hold the code bus is compared with the head of the expected queue, and the spacing between strobes is measured against the dwell that was sampled.

// File: rtl/ltseq_pkg.sv
package ltseq_pkg;
  // Segment split of the converter: low binary bits, then two thermometer
  // segments stepped above mid-scale, then the top thermometer segment.
  localparam int LSB_BITS = 4;
  localparam int SEG2_BITS = 3;
  localparam int SEG3_BITS = 4;
  localparam int TOP_BITS = 5;
  localparam int CODE_W = LSB_BITS + SEG2_BITS + SEG3_BITS + TOP_BITS;
  localparam int DWELL_W = 16;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             phase;
  } step_pos_t;
endpackage

// File: rtl/ltseq_code_map.sv
module ltseq_code_map #(
  parameter int LSB_BITS = 4,
  parameter int SEG2_BITS = 3,
  parameter int SEG3_BITS = 4,
  parameter int TOP_BITS = 5,
  parameter int IDX_W = 6,
  localparam int CODE_W = LSB_BITS + SEG2_BITS + SEG3_BITS + TOP_BITS
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              phase,
  output logic [CODE_W-1:0] code,
  output logic              is_top
);
  localparam int SEG2_N = (1 << SEG2_BITS) - 1;
  localparam int SEG3_N = (1 << SEG3_BITS) - 1;
  localparam int TOP_N = (1 << TOP_BITS) - 1;
  localparam int B_SEG2 = 1 + LSB_BITS;
  localparam int B_SEG3 = B_SEG2 + SEG2_N;
  localparam int B_TOP = B_SEG3 + SEG3_N;
  localparam int B_FULL = B_TOP + TOP_N;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  // Table entry arithmetic; the bench restates it with its own loops.
  function automatic logic [CODE_W-1:0] entry_code(input int k);
    logic [CODE_W-1:0] r;
    if (k == 0)
      r = '0;
    else if (k < B_SEG2)
      r = MID | (CODE_W'(1) << (k - 1));
    else if (k < B_SEG3)
      r = MID + (CODE_W'(k - B_SEG2 + 1) << LSB_BITS);
    else if (k < B_TOP)
      r = MID + (CODE_W'(k - B_SEG3 + 1) << (LSB_BITS + SEG2_BITS));
    else if (k < B_FULL)
      r = CODE_W'(k - B_TOP + 1) << (CODE_W - TOP_BITS);
    else
      r = '1;
    return r;
  endfunction

  function automatic logic in_top(input int k);
    return (k >= B_TOP) && (k < B_FULL);
  endfunction

  logic [CODE_W-1:0] base_code;

  always_comb begin
    base_code = entry_code(int'(idx));
    is_top = in_top(int'(idx));
    code = phase ? ~base_code : base_code;
  end
endmodule

// File: rtl/ltseq_dwell_timer.sv
module ltseq_dwell_timer #(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell,
  output logic               step_end
);
  logic [DWELL_W-1:0] dwell_q;
  logic [DWELL_W-1:0] cnt;
  logic [DWELL_W-1:0] last_cnt;

  // A zero dwell behaves as a one-cycle hold.
  function automatic logic [DWELL_W-1:0] hold_last(input logic [DWELL_W-1:0] d);
    return (d == '0) ? '0 : d - DWELL_W'(1);
  endfunction

  assign last_cnt = hold_last(dwell_q);
  assign step_end = run && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
      cnt <= '0;
    end else if (start) begin
      dwell_q <= dwell;
      cnt <= '0;
    end else if (run) begin
      cnt <= step_end ? '0 : cnt + DWELL_W'(1);
    end
  end
endmodule

// File: rtl/ltseq_step_walker.sv
module ltseq_step_walker #(
  parameter int IDX_W = 6,
  parameter int LAST_IDX = 58
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             interleave,
  input  logic             step_end,
  input  logic             is_top,
  output logic [IDX_W-1:0] idx,
  output logic             phase,
  output logic             run,
  output logic             done
);
  logic mode_q;
  logic at_last;
  logic want_comp;

  assign at_last = (idx == IDX_W'(LAST_IDX)) && !phase;
  assign want_comp = mode_q && is_top && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      phase <= 1'b0;
      run <= 1'b0;
      done <= 1'b0;
      mode_q <= 1'b0;
    end else if (start) begin
      idx <= '0;
      phase <= 1'b0;
      run <= 1'b1;
      done <= 1'b0;
      mode_q <= interleave;
    end else if (step_end) begin
      if (at_last) begin
        run <= 1'b0;
        done <= 1'b1;
      end else if (want_comp) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/linearity_seq.sv
module linearity_seq
  import ltseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               interleave,
  input  logic [DWELL_W-1:0] dwell,
  output logic [CODE_W-1:0]  code,
  output logic               strobe,
  output logic [IDX_W-1:0]   index,
  output logic               comp,
  output logic               done
);
  localparam int LAST_IDX = 1 + LSB_BITS + ((1 << SEG2_BITS) - 1)
                          + ((1 << SEG3_BITS) - 1) + ((1 << TOP_BITS) - 1);

  // Named internal events, visible to the bound checker.
  logic      step_end;
  logic      run;
  logic      is_top;
  step_pos_t pos;

  ltseq_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .dwell(dwell), .step_end(step_end)
  );

  ltseq_step_walker #(.IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .interleave(interleave),
    .step_end(step_end), .is_top(is_top),
    .idx(pos.idx), .phase(pos.phase), .run(run), .done(done)
  );

  ltseq_code_map #(
    .LSB_BITS(LSB_BITS), .SEG2_BITS(SEG2_BITS), .SEG3_BITS(SEG3_BITS),
    .TOP_BITS(TOP_BITS), .IDX_W(IDX_W)
  ) u_map (
    .idx(pos.idx), .phase(pos.phase), .code(code), .is_top(is_top)
  );

  assign strobe = step_end;
  assign index = pos.idx;
  assign comp = pos.phase;
endmodule

// File: rtl/linearity_seq_checker.sv
module linearity_seq_checker #(
  parameter int CODE_W = 16,
  parameter int IDX_W = 6,
  parameter int LOW_W = 11,
  parameter int LAST_IDX = 58
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] code,
  input logic              strobe,
  input logic [IDX_W-1:0]  index,
  input logic              comp,
  input logic              done,
  input logic              run
);
  // R3 / R6: the code is held while a step is under way, whatever the
  // mode and dwell inputs do.
  assert_code_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !strobe && !start |=> $stable(code));

  // R7: done is sticky until start.
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7: no capture request once the sweep has finished.
  assert_no_strobe_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe);

  // R7: the full-scale capture ends the sweep.
  assert_finish_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (index == IDX_W'(LAST_IDX)) && !comp && !start |=> done);

  // R8: start returns the sweep to its first entry.
  assert_restart_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (index == '0) && !comp && !done);

  // R5: a complement step carries a top-segment code inverted, so its low bits are all ones.
  assert_comp_low_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    comp |-> (&code[LOW_W-1:0]));

  // R5: a complement step lasts a single step.
  assert_comp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    comp && strobe && !start |=> !comp);
endmodule

bind linearity_seq linearity_seq_checker #(
  .CODE_W(ltseq_pkg::CODE_W),
  .IDX_W(ltseq_pkg::IDX_W),
  .LOW_W(ltseq_pkg::CODE_W - ltseq_pkg::TOP_BITS),
  .LAST_IDX(LAST_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .code(code), .strobe(strobe),
  .index(index), .comp(comp), .done(done), .run(run)
);

// File: tb/linearity_seq_tb.sv
module linearity_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        interleave = 1'b0;
  logic [15:0] dwell = 16'd0;
  logic [15:0] code;
  logic        strobe;
  logic [5:0]  index;
  logic        comp;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_strobe = 0;
  int exp_gap = 1;
  int pops = 0;
  bit run_on = 1'b0;
  bit hold_bad = 1'b0;
  logic [22:0] exp_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  linearity_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .interleave(interleave),
    .dwell(dwell), .code(code), .strobe(strobe), .index(index),
    .comp(comp), .done(done)
  );

  function automatic logic [22:0] item(input logic [15:0] c, input int i, input logic cp);
    return {c, 6'(i), cp};
  endfunction

  // Expected sweep, built from R2 and R5.
  task automatic build(input bit il);
    int n = 0;
    exp_q.delete();
    exp_q.push_back(item(16'h0000, n, 1'b0)); n++;
    for (int b = 0; b < 4; b++) begin
      exp_q.push_back(item(16'h8000 | (16'h1 << b), n, 1'b0)); n++;
    end
    for (int j = 1; j <= 7; j++) begin
      exp_q.push_back(item(16'h8000 + 16'(j * 16), n, 1'b0)); n++;
    end
    for (int j = 1; j <= 15; j++) begin
      exp_q.push_back(item(16'h8000 + 16'(j * 128), n, 1'b0)); n++;
    end
    for (int j = 1; j <= 31; j++) begin
      exp_q.push_back(item(16'(j * 2048), n, 1'b0));
      if (il) exp_q.push_back(item(~16'(j * 2048), n, 1'b1));
      n++;
    end
    exp_q.push_back(item(16'hFFFF, n, 1'b0));
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares the bus with the queue head on every cycle of a hold.
  always @(negedge clk) begin
    if (run_on && exp_q.size() > 0) begin
      logic [22:0] h;
      h = exp_q[0];
      if (strobe) begin
        check({code, index, comp} == h && !done, "R2/R5", "step at strobe",
              {9'd0, code, index, comp}, {9'd0, h});
        check(cyc - last_strobe == exp_gap, "R3/R4", "strobe spacing",
              cyc - last_strobe, exp_gap);
        last_strobe = cyc;
        void'(exp_q.pop_front());
        pops++;
        if (exp_q.size() == 0) run_on = 1'b0;
      end else if (code != h[22:7] && !hold_bad) begin
        hold_bad = 1'b1;
        check(1'b0, "R3/R6", "code during hold", code, h[22:7]);
      end
    end else if (!run_on && strobe && rst_n && !start) begin
      check(1'b0, "R7", "strobe outside sweep", 1, 0);
    end
  end

  task automatic kick(input bit il, input int d);
    @(posedge clk); #1;
    run_on = 1'b0;
    build(il);
    interleave = il;
    dwell = 16'(d);
    exp_gap = (d == 0) ? 1 : d;
    start = 1'b1;
    last_strobe = cyc;
    pops = 0;
    hold_bad = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    run_on = 1'b1;
  endtask

  task automatic wait_end(input string req);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 20000) check(1'b0, "watchdog", req, guard, 0);
    @(negedge clk);
    check(done == 1'b1, "R7", "done after full scale", done, 1);
    repeat (6) @(negedge clk);
    check(done == 1'b1 && code == 16'hFFFF, "R7", "done held, code kept",
          {15'd0, done, code}, {15'd0, 1'b1, 16'hFFFF});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(code == 16'h0 && index == 6'd0 && !strobe && !comp && !done,
          "R1", "reset state", {code, index, strobe, comp, done}, 0);

    // R2 R3 R4: table order, dwell 3.
    kick(1'b0, 3);
    wait_end("R2 table run");

    // R5: interleave, dwell 2.
    kick(1'b1, 2);
    wait_end("R5 interleave run");

    // R3: zero dwell behaves as one cycle.
    kick(1'b0, 0);
    wait_end("R3 zero dwell");

    // R6: inputs changed mid-run are ignored.
    kick(1'b1, 2);
    repeat (20) @(posedge clk);
    #1 interleave = 1'b0;
    dwell = 16'd7;
    wait_end("R6 mid-run change");

    // R8: restart after ten readings.
    kick(1'b0, 4);
    while (pops < 10) @(negedge clk);
    check(!done, "R8", "still running before restart", done, 0);
    kick(1'b0, 4);
    @(negedge clk);
    check(index == 6'd0 && code == 16'h0 && !comp && !done, "R8",
          "restart at first entry", {code, index}, 0);
    wait_end("R8 restart run");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule